// File: doc/BRIEF.md
# Wiper Preset and Save Sequencer

This block sits between the serial command decoder of a multi-channel digital potentiometer and the per-channel volatile wiper registers. It keeps a behavioural nonvolatile store, one location per wiper channel plus one more location whose two low bits drive two latched digital outputs. It moves values between the store and the wipers when power comes up, when a command asks for it, and when a hardware preset pin is pulsed.

Slow operations take a fixed number of clock cycles, each set by a parameter. These are the store writes, the reset-all command and the two readback commands. During that window the ready flag is low. During a store write the serial shift register is also told to hold still. A write-protect input keeps the store from being changed but still allows restores. The preset pin first forces every wiper to midscale while it is low, and then reloads the saved values on its rising edge.

Top module: `nvseq_top`

## Requirements
- R1: After reset is released, every wiper takes its stored value with no command. An unprogrammed store location holds midscale, 1 << (WIDTH-1), which is 0x80 at the default 8 bits. The digital outputs take bits [1:0] of location NUM_CH, so they reset to 0. After reset, ready is 1 and shiftLock is 0.
- R2: Code 1 (restore) with address a < NUM_CH loads wiper a from store location a. With a = NUM_CH it loads the digital outputs from bits [1:0] of that location. An address above NUM_CH is ignored. Restore takes no busy time.
- R3: Code 3 writes cmdData into store location a. Code 2 copies wiper a into store location a (for a = NUM_CH it copies the digital outputs, zero-extended). The store changes only when the busy window ends.
- R4: Code 8 (reset-all) reloads every wiper and both digital outputs from the store in the cycle it is accepted. The address field is ignored.
- R5: Once a command is accepted, ready stays low for exactly SAVE_CYC cycles for codes 2 and 3, RESET_CYC cycles for code 8 and READ_CYC cycles for codes 9 and 10. Code 1 and all other codes leave ready high.
- R6: shiftLock is high exactly while a code 2 or code 3 operation is busy, and low for every other operation.
- R7: A command presented while ready is low is ignored entirely.
- R8: While writeProtN is 0, codes 2 and 3 are ignored and the store is unchanged. Codes 1, 8, 9 and 10 still act.
- R9: While the synchronised preset pin is low, every wiper is held at midscale, and restore commands (codes 1 and 8) are ignored. Wipers reach midscale within 3 cycles of the pin falling.
- R10: On the synchronised rising edge of the preset pin, every wiper reloads from its store location. The digital outputs are not touched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset, models power-on |
| cmdValid | input | 1 | One-cycle command strobe from the decoder |
| cmdCode | input | 4 | Command code |
| cmdAddr | input | 4 | Channel / store location address |
| cmdData | input | WIDTH | Data for the code 3 store write |
| presetN | input | 1 | Asynchronous hardware preset pin, active low |
| writeProtN | input | 1 | Write protect, active low |
| wiperBus | output | NUM_CH*WIDTH | Wiper registers, channel c at [c*WIDTH +: WIDTH] |
| digOut | output | 2 | Latched digital outputs |
| ready | output | 1 | High when no slow operation is in progress |
| shiftLock | output | 1 | Hold request for the serial shift register |

## Verification
The bench goes after the cases a sequencer like this commonly gets wrong, and each failure shows up at the ports:
- A save that copies from the wrong source would return the written data instead of the wiper value on a later reset-all.
- A write-protect gate that leaks would let a protected store write show up on the next restore.
- A command accepted while busy would overwrite a store location that a later restore exposes.
- A preset that ignores the suppression rule would let a restore pull a wiper off midscale while the pin is low.
- An off-by-one busy counter would show up as a ready-low count that differs from the parameter.

// File: rtl/nvseq_pkg.sv
package nvseq_pkg;
  localparam logic [3:0] CODE_RESTORE    = 4'd1;
  localparam logic [3:0] CODE_SAVE_WIPER = 4'd2;
  localparam logic [3:0] CODE_STORE_DATA = 4'd3;
  localparam logic [3:0] CODE_RELOAD_ALL = 4'd8;
  localparam logic [3:0] CODE_READ_STORE = 4'd9;
  localparam logic [3:0] CODE_READ_WIPER = 4'd10;

  typedef struct packed {
    logic       loadAll;        // wipers and digital outputs from store
    logic       reloadWipers;   // wipers only (preset rising edge)
    logic       loadOne;        // single location restore
    logic       forceMid;       // hold wipers at midscale
    logic       commit;         // write pending value into store
    logic       commitFromData; // commit source: data (1) or wiper (0)
    logic [3:0] addr;
  } strobe_t;
endpackage

// File: rtl/nvseq_ctrl.sv
module nvseq_ctrl
  import nvseq_pkg::*;
#(
  parameter int NUM_CH    = 2,
  parameter int WIDTH     = 8,
  parameter int SAVE_CYC  = 20,
  parameter int RESET_CYC = 8,
  parameter int READ_CYC  = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdValid,
  input  logic [3:0]       cmdCode,
  input  logic [3:0]       cmdAddr,
  input  logic [WIDTH-1:0] cmdData,
  input  logic             presetN,
  input  logic             writeProtN,
  output strobe_t          strb,
  output logic [WIDTH-1:0] pendData,
  output logic             ready,
  output logic             shiftLock
);
  localparam int MAX_A   = (SAVE_CYC > RESET_CYC) ? SAVE_CYC : RESET_CYC;
  localparam int MAX_DUR = (MAX_A > READ_CYC) ? MAX_A : READ_CYC;
  localparam int CNT_W   = $clog2(MAX_DUR + 1);

  logic             presetMeta, presetSync, presetPrev;
  logic             bootPending;
  logic [CNT_W-1:0] busyCnt;
  logic             lockActive;
  logic [3:0]       pendAddr;
  logic             pendFromData;

  logic idle, addrOk, presetLow, presetRise;
  logic accept, acceptSave, acceptRestore, acceptReload, acceptRead;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      presetMeta <= 1'b1;
      presetSync <= 1'b1;
      presetPrev <= 1'b1;
    end else begin
      presetMeta <= presetN;
      presetSync <= presetMeta;
      presetPrev <= presetSync;
    end
  end

  assign presetLow  = !presetSync;
  assign presetRise = presetSync && !presetPrev;

  assign idle   = (busyCnt == '0);
  assign addrOk = (cmdAddr <= 4'(NUM_CH));
  assign accept = cmdValid && idle;

  assign acceptSave    = accept && writeProtN && addrOk &&
                         (cmdCode == CODE_SAVE_WIPER || cmdCode == CODE_STORE_DATA);
  assign acceptRestore = accept && addrOk && !presetLow && (cmdCode == CODE_RESTORE);
  assign acceptReload  = accept && !presetLow && (cmdCode == CODE_RELOAD_ALL);
  assign acceptRead    = accept && addrOk &&
                         (cmdCode == CODE_READ_STORE || cmdCode == CODE_READ_WIPER);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bootPending  <= 1'b1;
      busyCnt      <= '0;
      lockActive   <= 1'b0;
      pendAddr     <= '0;
      pendFromData <= 1'b0;
      pendData     <= '0;
    end else begin
      bootPending <= 1'b0;
      if (acceptSave)        busyCnt <= CNT_W'(SAVE_CYC);
      else if (acceptReload) busyCnt <= CNT_W'(RESET_CYC);
      else if (acceptRead)   busyCnt <= CNT_W'(READ_CYC);
      else if (!idle)        busyCnt <= busyCnt - 1'b1;

      if (acceptSave) begin
        lockActive   <= 1'b1;
        pendAddr     <= cmdAddr;
        pendFromData <= (cmdCode == CODE_STORE_DATA);
        pendData     <= cmdData;
      end else if (busyCnt == CNT_W'(1)) begin
        lockActive <= 1'b0;
      end
    end
  end

  always_comb begin
    strb                = '0;
    strb.loadAll        = bootPending || acceptReload;
    strb.reloadWipers   = presetRise;
    strb.loadOne        = acceptRestore;
    strb.forceMid       = presetLow;
    strb.commit         = lockActive && (busyCnt == CNT_W'(1));
    strb.commitFromData = pendFromData;
    strb.addr           = acceptRestore ? cmdAddr : pendAddr;
  end

  assign ready     = idle;
  assign shiftLock = lockActive;

  // R6: the hold request never appears outside a busy window
  a_r6_lock_only_when_busy: assert property (@(posedge clk) disable iff (!rstN)
    shiftLock |-> !ready);

  // R5: ready only returns after the counter passed through its last step
  a_r5_ready_after_last_step: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ready) |-> $past(busyCnt) == CNT_W'(1));

  // R7: a busy window is never restarted by a new command
  a_r7_no_restart_when_busy: assert property (@(posedge clk) disable iff (!rstN)
    (!ready && busyCnt != CNT_W'(1)) |=> !ready && busyCnt == $past(busyCnt) - 1'b1);

  // R8: a store write is only ever started with write protect released
  a_r8_save_needs_unprotected: assert property (@(posedge clk) disable iff (!rstN)
    $rose(shiftLock) |-> $past(writeProtN));
endmodule

// File: rtl/nvseq_datapath.sv
module nvseq_datapath
  import nvseq_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int WIDTH  = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  strobe_t                 strb,
  input  logic [WIDTH-1:0]        pendData,
  output logic [NUM_CH*WIDTH-1:0] wiperBus,
  output logic [1:0]              digOut
);
  localparam int          LOCS = NUM_CH + 1;
  localparam logic [WIDTH-1:0] MID = WIDTH'(1) << (WIDTH - 1);

  logic [WIDTH-1:0] store [LOCS];
  logic [WIDTH-1:0] wiper [NUM_CH];

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_wiper
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                   wiper[ch] <= '0;
      else if (strb.forceMid)                      wiper[ch] <= MID;
      else if (strb.loadAll || strb.reloadWipers)  wiper[ch] <= store[ch];
      else if (strb.loadOne && strb.addr == 4'(ch)) wiper[ch] <= store[ch];
    end
    assign wiperBus[ch*WIDTH +: WIDTH] = wiper[ch];

    // R9: a midscale hold always lands on the following edge
    a_r9_mid_hold: assert property (@(posedge clk) disable iff (!rstN)
      strb.forceMid |=> wiper[ch] == MID);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) digOut <= '0;
    else if (strb.loadAll || (strb.loadOne && strb.addr == 4'(NUM_CH)))
      digOut <= store[NUM_CH][1:0];
  end

  for (genvar loc = 0; loc < LOCS; loc++) begin : g_store
    logic [WIDTH-1:0] fromReg;
    if (loc < NUM_CH) begin : g_chan
      assign fromReg = wiper[loc];
    end else begin : g_outs
      assign fromReg = {{(WIDTH-2){1'b0}}, digOut};
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) store[loc] <= MID;
      else if (strb.commit && strb.addr == 4'(loc))
        store[loc] <= strb.commitFromData ? pendData : fromReg;
    end

    // R3: a store location changes only on its own commit
    a_r3_store_write_only_on_commit: assert property (@(posedge clk) disable iff (!rstN)
      !(strb.commit && strb.addr == 4'(loc)) |=> $stable(store[loc]));
  end
endmodule

// File: rtl/nvseq_top.sv
module nvseq_top
  import nvseq_pkg::*;
#(
  parameter int NUM_CH    = 2,
  parameter int WIDTH     = 8,
  parameter int SAVE_CYC  = 20,
  parameter int RESET_CYC = 8,
  parameter int READ_CYC  = 4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    cmdValid,
  input  logic [3:0]              cmdCode,
  input  logic [3:0]              cmdAddr,
  input  logic [WIDTH-1:0]        cmdData,
  input  logic                    presetN,
  input  logic                    writeProtN,
  output logic [NUM_CH*WIDTH-1:0] wiperBus,
  output logic [1:0]              digOut,
  output logic                    ready,
  output logic                    shiftLock
);
  strobe_t          strb;
  logic [WIDTH-1:0] pendData;

  nvseq_ctrl #(
    .NUM_CH(NUM_CH), .WIDTH(WIDTH), .SAVE_CYC(SAVE_CYC),
    .RESET_CYC(RESET_CYC), .READ_CYC(READ_CYC)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdCode(cmdCode),
    .cmdAddr(cmdAddr), .cmdData(cmdData), .presetN(presetN),
    .writeProtN(writeProtN), .strb(strb), .pendData(pendData),
    .ready(ready), .shiftLock(shiftLock)
  );

  nvseq_datapath #(.NUM_CH(NUM_CH), .WIDTH(WIDTH)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .pendData(pendData),
    .wiperBus(wiperBus), .digOut(digOut)
  );
endmodule

// File: tb/nvseq_top_tb.sv
`timescale 1ns/1ps
module nvseq_top_tb;
  localparam int NUM_CH = 2;
  localparam int WIDTH  = 8;
  localparam int SAVE_C = 20;
  localparam int RST_C  = 8;
  localparam int READ_C = 4;
  localparam int NVEC   = 17;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdValid = 1'b0;
  logic [3:0] cmdCode = '0;
  logic [3:0] cmdAddr = '0;
  logic [WIDTH-1:0] cmdData = '0;
  logic presetN = 1'b1;
  logic writeProtN = 1'b1;
  logic [NUM_CH*WIDTH-1:0] wiperBus;
  logic [1:0] digOut;
  logic ready, shiftLock;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  nvseq_top #(.NUM_CH(NUM_CH), .WIDTH(WIDTH), .SAVE_CYC(SAVE_C),
              .RESET_CYC(RST_C), .READ_CYC(READ_C)) u_dut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdCode(cmdCode),
    .cmdAddr(cmdAddr), .cmdData(cmdData), .presetN(presetN),
    .writeProtN(writeProtN), .wiperBus(wiperBus), .digOut(digOut),
    .ready(ready), .shiftLock(shiftLock));

  // code, addr, data, writeProtN, expected wiper0, wiper1, digOut
  localparam logic [34:0] VECS [NVEC] = '{
    {4'd3, 4'd0, 8'h3C, 1'b1, 8'h80, 8'h80, 2'd0},
    {4'd1, 4'd0, 8'h00, 1'b1, 8'h3C, 8'h80, 2'd0},
    {4'd3, 4'd1, 8'hA5, 1'b1, 8'h3C, 8'h80, 2'd0},
    {4'd3, 4'd2, 8'h03, 1'b1, 8'h3C, 8'h80, 2'd0},
    {4'd8, 4'd0, 8'h00, 1'b1, 8'h3C, 8'hA5, 2'd3},
    {4'd3, 4'd0, 8'h11, 1'b1, 8'h3C, 8'hA5, 2'd3},
    {4'd3, 4'd0, 8'h22, 1'b0, 8'h3C, 8'hA5, 2'd3},
    {4'd1, 4'd0, 8'h00, 1'b0, 8'h11, 8'hA5, 2'd3},
    {4'd3, 4'd1, 8'h5A, 1'b1, 8'h11, 8'hA5, 2'd3},
    {4'd2, 4'd1, 8'h00, 1'b0, 8'h11, 8'hA5, 2'd3},
    {4'd1, 4'd1, 8'h00, 1'b1, 8'h11, 8'h5A, 2'd3},
    {4'd3, 4'd2, 8'h00, 1'b1, 8'h11, 8'h5A, 2'd3},
    {4'd1, 4'd2, 8'h00, 1'b1, 8'h11, 8'h5A, 2'd0},
    {4'd3, 4'd1, 8'hC3, 1'b1, 8'h11, 8'h5A, 2'd0},
    {4'd2, 4'd1, 8'h00, 1'b1, 8'h11, 8'h5A, 2'd0},
    {4'd8, 4'd0, 8'h00, 1'b1, 8'h11, 8'h5A, 2'd0},
    {4'd9, 4'd0, 8'h00, 1'b0, 8'h11, 8'h5A, 2'd0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [3:0] c, input logic [3:0] a, input logic [WIDTH-1:0] d);
    @(negedge clk);
    cmdValid = 1'b1; cmdCode = c; cmdAddr = a; cmdData = d;
    @(negedge clk);
    cmdValid = 1'b0;
  endtask

  task automatic waitReady(output int lowCount);
    lowCount = 0;
    while (!ready && lowCount < 1000) begin
      lowCount++;
      @(negedge clk);
    end
  endtask

  task automatic idleCycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic int expDur(input logic [3:0] c, input logic wp);
    if ((c == 4'd2 || c == 4'd3) && wp) return SAVE_C;
    if (c == 4'd8) return RST_C;
    if (c == 4'd9 || c == 4'd10) return READ_C;
    return 0;
  endfunction

  function automatic logic [7:0] w(input int ch);
    return wiperBus[ch*WIDTH +: WIDTH];
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !finished) begin
      finished = 1;
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected<=100000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int lows;
    idleCycles(3);
    rstN = 1'b1;
    idleCycles(3);
    // R1: power-on state
    check("R1 wiper0 after power-on", w(0), 8'h80);
    check("R1 wiper1 after power-on", w(1), 8'h80);
    check("R1 digOut after power-on", digOut, 0);
    check("R1 ready after power-on", ready, 1);
    check("R1 shiftLock after power-on", shiftLock, 0);

    // Table walk: R2 R3 R4 R5 R8
    for (int i = 0; i < NVEC; i++) begin
      writeProtN = VECS[i][18];
      issue(VECS[i][34:31], VECS[i][30:27], VECS[i][26:19]);
      waitReady(lows);
      idleCycles(2);
      check($sformatf("R5 ready-low cycles vec %0d", i), lows,
            expDur(VECS[i][34:31], VECS[i][18]));
      check($sformatf("R2/R3/R4/R8 wiper0 vec %0d", i), w(0), VECS[i][17:10]);
      check($sformatf("R2/R3/R4/R8 wiper1 vec %0d", i), w(1), VECS[i][9:2]);
      check($sformatf("R2/R4 digOut vec %0d", i), digOut, VECS[i][1:0]);
    end
    writeProtN = 1'b1;

    // R6: lock during save, not during readback or reload
    issue(4'd3, 4'd1, 8'h77);
    check("R6 shiftLock during save", shiftLock, 1);
    // R7: command while busy is ignored
    issue(4'd3, 4'd0, 8'h99);
    waitReady(lows);
    check("R6 shiftLock after save", shiftLock, 0);
    issue(4'd1, 4'd0, 8'h00);
    idleCycles(1);
    check("R7 store0 untouched by busy command", w(0), 8'h11);
    issue(4'd1, 4'd1, 8'h00);
    idleCycles(1);
    check("R3 store1 committed data", w(1), 8'h77);
    issue(4'd10, 4'd0, 8'h00);
    check("R6 shiftLock low during readback", shiftLock, 0);
    waitReady(lows);
    check("R5 readback ready-low cycles", lows, READ_C);
    issue(4'd8, 4'd0, 8'h00);
    check("R6 shiftLock low during reload", shiftLock, 0);
    waitReady(lows);

    // R2: out-of-range address ignored
    issue(4'd3, 4'd7, 8'h44);
    check("R2 bad address leaves ready high", ready, 1);

    // R9: preset low forces midscale, restores suppressed
    presetN = 1'b0;
    idleCycles(4);
    check("R9 wiper0 midscale", w(0), 8'h80);
    check("R9 wiper1 midscale", w(1), 8'h80);
    issue(4'd1, 4'd0, 8'h00);
    idleCycles(1);
    check("R9 restore suppressed", w(0), 8'h80);
    issue(4'd8, 4'd0, 8'h00);
    idleCycles(1);
    check("R9 reload suppressed, ready stays high", ready, 1);
    check("R9 reload suppressed, digOut kept", digOut, 0);
    // R10: rising edge reloads
    presetN = 1'b1;
    idleCycles(5);
    check("R10 wiper0 reloaded", w(0), 8'h11);
    check("R10 wiper1 reloaded", w(1), 8'h77);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule